// File: doc/BRIEF.md
# Clock Failure Detector

This block watches a primary clock that arrives from outside the chip and reports when that clock stops toggling. It builds a slow sample clock by dividing a low-frequency internal reference by a fixed ratio, 64 by default. A window latch is set by every falling edge of the monitored clock and cleared by every rising edge of the sample clock. The latch is judged when the sample clock next falls. If no falling edge arrived during that high half-cycle, the clock is declared dead.

All work is done in a fast observation clock domain. The monitored clock and the reference pass through two-flop synchronizers, and edge detectors turn them into single-cycle events. This replaces an asynchronous set/reset latch.

The `arm` input stays low while the oscillator start-up timer runs. While disarmed, the divider and the window latch are held cleared, so the first window after arming is a complete one. The failure flag is sticky. Only `fail_clr` or reset removes it.

Top module: `clk_fail_monitor`

## Requirements
- R1: While `rst_n` is low, `fail_det` is 0, and an asserted `fail_det` drops to 0 as soon as `rst_n` goes low. Reset is released through a two-stage synchronizer, so the logic starts working on the third `obs_clk` rising edge after `rst_n` rises.
- R2: While `arm` is 0, `fail_det` never changes from 0 to 1, whatever the monitored clock and the reference do.
- R3: The sample clock advances on every synchronized rising edge of `ref_clk` while armed. Counting from arming, its rising edge falls on the 32nd such edge and its falling edge on the 64th, and the pattern then repeats every 64 edges (`DIV_RATIO`=64, half = `DIV_RATIO`/2).
- R4: If the monitored clock is stuck at 0 or stuck at 1 from the moment of arming, `fail_det` is still 0 after the 63rd reference rising edge and is 1 after the 64th.
- R5: One falling edge of `ext_clk` during the high half of the sample clock prevents a failure at the evaluation that ends that half. This counts an edge seen in the evaluation cycle itself. A clock that keeps toggling never raises `fail_det`.
- R6: Falling edges of `ext_clk` that occur only during the low half of the sample clock do not prevent a failure, because the sample clock's rising edge clears the window latch. A falling edge in the same cycle as that rising edge wins and leaves the latch set.
- R7: Once 1, `fail_det` stays 1, even after `arm` drops, until `fail_clr` is 1 at an `obs_clk` rising edge. When a new failure is judged in the same cycle as a clear, `fail_det` stays 1.
- R8: Dropping `arm` returns the divider to its start and clears the window latch. After re-arming, a stopped clock is flagged only after a full 64 reference edges.
- R9: `ext_clk` and `ref_clk` each pass through two synchronizing flops and one edge-detect flop. `fail_det` changes on the `obs_clk` rising edge at which the evaluating reference edge is detected, so it matches a cycle-exact reference on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| obs_clk | input | 1 | Fast observation clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_clk | input | 1 | Monitored primary clock, asynchronous to `obs_clk` |
| ref_clk | input | 1 | Low-frequency internal reference, asynchronous to `obs_clk` |
| arm | input | 1 | 1 = start-up timer expired, detection enabled; 0 = detector held idle |
| fail_clr | input | 1 | 1 at a clock edge clears a latched failure |
| fail_det | output | 1 | 1 = monitored clock judged stopped; sticky |

## Verification
The bench times the first evaluation after arming to the exact reference edge. A divider that is not held while disarmed, or one that judges a full period or a single quarter, shows up as a flag raised one window early or late. It places a lone falling edge of the monitored clock first in the low half and then in the high half of a window. A latch that is not cleared on the sample rising edge would hide the first failure, and one that is judged too early would flag the second. Other cases catch a flag that is not sticky, a stuck-high clock that is read as alive, and a disarm that does not restart the window. A cycle-exact behavioural model, compared on every clock, catches an off-by-one in synchronizer depth or a clear that wins over a new failure.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

  // Default divide ratio from reference to sample clock (must be even, >= 4).
  localparam int unsigned CFM_DIV_DEFAULT  = 64;
  // Default synchronizer depth for asynchronous inputs.
  localparam int unsigned CFM_SYNC_DEFAULT = 2;

  // Counter width needed to hold 0 .. div-1.
  function automatic int unsigned cfm_cnt_w(input int unsigned div);
    return (div <= 2) ? 1 : $clog2(div);
  endfunction

endpackage

// File: rtl/cfm_rst_sync.sv
module cfm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/cfm_edge_sync.sv
module cfm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl_now,
  output logic lvl_prev
);

  // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value.
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign lvl_now  = chain_q[STAGES-1];
  assign lvl_prev = chain_q[STAGES];

endmodule

// File: rtl/cfm_sample_div.sv
module cfm_sample_div #(
  parameter int unsigned DIV_RATIO = 64,
  parameter int unsigned CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             ref_rise,
  output logic             samp_rise,
  output logic             samp_fall,
  output logic [CNT_W-1:0] div_cnt
);

  localparam int unsigned HALF = DIV_RATIO / 2;
  localparam logic [CNT_W-1:0] RISE_AT = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(DIV_RATIO - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // The counter only advances on a reference edge while armed.
  assign cnt_en = arm & ref_rise;

  always_comb begin
    cnt_d = cnt_q;
    if (!arm) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Sample clock is low for counts 0..HALF-1 and high for HALF..DIV-1.
  assign samp_rise = cnt_en & (cnt_q == RISE_AT);
  assign samp_fall = cnt_en & (cnt_q == LAST);
  assign div_cnt   = cnt_q;

endmodule

// File: rtl/cfm_fail_judge.sv
module cfm_fail_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic ext_fall,
  input  logic samp_rise,
  input  logic samp_fall,
  input  logic fail_clr,
  output logic win_latch,
  output logic eval_fail,
  output logic fail_det
);

  logic latch_q, latch_d;
  logic fail_q, fail_d;

  // Window latch: a falling edge of the monitored clock sets it and
  // wins over a clear in the same cycle.
  always_comb begin
    latch_d = latch_q;
    if (!arm) begin
      latch_d = 1'b0;
    end else if (ext_fall) begin
      latch_d = 1'b1;
    end else if (samp_rise) begin
      latch_d = 1'b0;
    end
  end

  // An edge seen in the evaluation cycle itself still counts.
  assign eval_fail = samp_fall & ~(latch_q | ext_fall);

  always_comb begin
    fail_d = fail_q;
    if (eval_fail) begin
      fail_d = 1'b1;
    end else if (fail_clr) begin
      fail_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      latch_q <= latch_d;
      fail_q  <= fail_d;
    end
  end

  assign win_latch = latch_q;
  assign fail_det  = fail_q;

endmodule

// File: rtl/clk_fail_monitor.sv
module clk_fail_monitor #(
  parameter int unsigned DIV_RATIO   = cfm_pkg::CFM_DIV_DEFAULT,
  parameter int unsigned SYNC_STAGES = cfm_pkg::CFM_SYNC_DEFAULT
) (
  input  logic obs_clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic ref_clk,
  input  logic arm,
  input  logic fail_clr,
  output logic fail_det
);

  localparam int unsigned CNT_W  = cfm_pkg::cfm_cnt_w(DIV_RATIO);
  localparam int unsigned N_SYNC = 2;   // index 0: monitored clock, 1: reference

  logic              rst_int_n;
  logic [N_SYNC-1:0] raw_in;
  logic [N_SYNC-1:0] lvl_now;
  logic [N_SYNC-1:0] lvl_prev;
  logic              ext_fall;
  logic              ref_rise;
  logic              samp_rise;
  logic              samp_fall;
  logic [CNT_W-1:0]  div_cnt;
  logic              win_latch;
  logic              eval_fail;

  cfm_rst_sync u_rst_sync (
    .clk        (obs_clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign raw_in = {ref_clk, ext_clk};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    cfm_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (obs_clk),
      .rst_n    (rst_int_n),
      .async_in (raw_in[g]),
      .lvl_now  (lvl_now[g]),
      .lvl_prev (lvl_prev[g])
    );
  end

  assign ext_fall = lvl_prev[0] & ~lvl_now[0];
  assign ref_rise = ~lvl_prev[1] & lvl_now[1];

  cfm_sample_div #(.DIV_RATIO(DIV_RATIO), .CNT_W(CNT_W)) u_div (
    .clk       (obs_clk),
    .rst_n     (rst_int_n),
    .arm       (arm),
    .ref_rise  (ref_rise),
    .samp_rise (samp_rise),
    .samp_fall (samp_fall),
    .div_cnt   (div_cnt)
  );

  cfm_fail_judge u_judge (
    .clk       (obs_clk),
    .rst_n     (rst_int_n),
    .arm       (arm),
    .ext_fall  (ext_fall),
    .samp_rise (samp_rise),
    .samp_fall (samp_fall),
    .fail_clr  (fail_clr),
    .win_latch (win_latch),
    .eval_fail (eval_fail),
    .fail_det  (fail_det)
  );

endmodule

// File: rtl/cfm_checker.sv
module cfm_checker #(
  parameter int unsigned CNT_W = 6
) (
  input logic             obs_clk,
  input logic             rst_int_n,
  input logic             arm,
  input logic             fail_clr,
  input logic             fail_det,
  input logic             ext_fall,
  input logic             ref_rise,
  input logic             samp_rise,
  input logic             samp_fall,
  input logic             win_latch,
  input logic             eval_fail,
  input logic [CNT_W-1:0] div_cnt
);

  p_reset_idle_r1: assert property (@(posedge obs_clk)
    !rst_int_n |-> !fail_det);

  p_disarmed_quiet_r2: assert property (@(posedge obs_clk) disable iff (!rst_int_n)
    (!arm && !fail_det) |=> !fail_det);

  p_div_step_r3: assert property (@(posedge obs_clk) disable iff (!rst_int_n)
    (arm && !ref_rise) |=> $stable(div_cnt));

  p_fail_at_window_end_r4: assert property (@(posedge obs_clk) disable iff (!rst_int_n)
    $rose(fail_det) |-> $past(samp_fall));

  p_fall_sets_latch_r5: assert property (@(posedge obs_clk) disable iff (!rst_int_n)
    (arm && ext_fall) |=> win_latch);

  p_rise_clears_latch_r6: assert property (@(posedge obs_clk) disable iff (!rst_int_n)
    (arm && samp_rise && !ext_fall) |=> !win_latch);

  p_sticky_r7: assert property (@(posedge obs_clk) disable iff (!rst_int_n)
    (fail_det && !fail_clr) |=> fail_det);

  p_clear_r7: assert property (@(posedge obs_clk) disable iff (!rst_int_n)
    (fail_clr && !eval_fail) |=> !fail_det);

  p_div_held_r8: assert property (@(posedge obs_clk) disable iff (!rst_int_n)
    !arm |=> (div_cnt == '0));

endmodule

bind clk_fail_monitor cfm_checker #(.CNT_W(CNT_W)) u_chk (
  .obs_clk   (obs_clk),
  .rst_int_n (rst_int_n),
  .arm       (arm),
  .fail_clr  (fail_clr),
  .fail_det  (fail_det),
  .ext_fall  (ext_fall),
  .ref_rise  (ref_rise),
  .samp_rise (samp_rise),
  .samp_fall (samp_fall),
  .win_latch (win_latch),
  .eval_fail (eval_fail),
  .div_cnt   (div_cnt)
);

// File: tb/clk_fail_monitor_tb.sv
module clk_fail_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 64;
  localparam int WATCHDOG   = 150000;

  logic obs_clk = 1'b0;
  logic rst_n   = 1'b1;
  logic ext_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic arm     = 1'b0;
  logic fail_clr = 1'b0;
  logic fail_det;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  // Stimulus state: reference phase 0..7 (high for 0..3), monitored clock mode.
  int ref_ph    = 7;
  int ref_rises = 0;
  int ext_mode  = 2;   // 0 stuck low, 1 stuck high, 2 toggling
  int ext_div   = 0;
  int base      = 0;

  clk_fail_monitor u_dut (
    .obs_clk  (obs_clk),
    .rst_n    (rst_n),
    .ext_clk  (ext_clk),
    .ref_clk  (ref_clk),
    .arm      (arm),
    .fail_clr (fail_clr),
    .fail_det (fail_det)
  );

  always #(CLK_PERIOD/2) obs_clk = ~obs_clk;

  // Input drivers, changed on the falling edge of the observation clock.
  always @(negedge obs_clk) begin
    ref_ph <= (ref_ph + 1) % 8;
    ref_clk <= (((ref_ph + 1) % 8) < 4);
    if (((ref_ph + 1) % 8) == 0) ref_rises <= ref_rises + 1;
    if (ext_mode == 2) begin
      ext_div <= (ext_div + 1) % 3;
      if (ext_div == 2) ext_clk <= ~ext_clk;
    end else begin
      ext_clk <= (ext_mode == 1);
    end
  end

  // Behavioural reference model, cycle exact.
  int m_rc = 0;
  bit m_eq[$];
  bit m_rq[$];
  int m_cnt = 0;
  bit m_latch = 1'b0;
  bit m_fail  = 1'b0;

  always @(posedge obs_clk) begin
    bit fall, rrise, srise, sfall, judge;
    if (!rst_n || m_rc < 2) begin
      if (!rst_n) m_rc = 0; else m_rc = m_rc + 1;
      m_eq = '{0, 0, 0};
      m_rq = '{0, 0, 0};
      m_cnt = 0; m_latch = 0; m_fail = 0;
    end else begin
      fall  = m_eq[2] && !m_eq[1];
      rrise = !m_rq[2] && m_rq[1];
      srise = arm && rrise && (m_cnt == DIV/2 - 1);
      sfall = arm && rrise && (m_cnt == DIV - 1);
      judge = sfall && !(m_latch || fall);
      if (judge) m_fail = 1;
      else if (fail_clr) m_fail = 0;
      if (!arm) m_latch = 0;
      else if (fall) m_latch = 1;
      else if (srise) m_latch = 0;
      if (!arm) m_cnt = 0;
      else if (rrise) m_cnt = (m_cnt + 1) % DIV;
      void'(m_eq.pop_back()); m_eq.push_front(ext_clk);
      void'(m_rq.pop_back()); m_rq.push_front(ref_clk);
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: fail_det=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // R9: compare with the model every cycle, a quarter period after the edge.
  always @(posedge obs_clk) begin
    #(CLK_PERIOD/4);
    if (!done) check("R9 cycle model", fail_det, m_fail);
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge obs_clk) begin
    cyc++;
    if (cyc >= WATCHDOG && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog R9: cycles=%0d expected < %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic arm_after_fall();
    while (ref_ph != 4) @(posedge obs_clk);
    @(negedge obs_clk);
    arm = 1'b1;
    base = ref_rises;
  endtask

  task automatic wait_rises(input int target, input int extra);
    while (ref_rises < target) @(posedge obs_clk);
    repeat (extra) @(negedge obs_clk);
  endtask

  task automatic pulse_clr();
    @(negedge obs_clk); fail_clr = 1'b1;
    @(negedge obs_clk); fail_clr = 1'b0;
  endtask

  task automatic ext_pulse();
    @(negedge obs_clk); ext_mode = 1;
    repeat (4) @(negedge obs_clk);
    ext_mode = 0;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (5) @(negedge obs_clk);
    check("R1 in reset", fail_det, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge obs_clk);
    check("R1 after release", fail_det, 1'b0);

    // R2: stopped clock while disarmed
    ext_mode = 0;
    repeat (1500) @(negedge obs_clk);
    check("R2 disarmed", fail_det, 1'b0);

    // R5: running clock over several windows
    ext_mode = 2;
    arm_after_fall();
    repeat (1800) @(negedge obs_clk);
    check("R5 running clock", fail_det, 1'b0);

    // R3 / R4: stuck low from arming, exact edge
    arm = 1'b0; ext_mode = 0;
    repeat (10) @(negedge obs_clk);
    arm_after_fall();
    wait_rises(base + 63, 7);
    check("R3 before 64th edge", fail_det, 1'b0);
    wait_rises(base + 64, 3);
    check("R3 after 64th edge", fail_det, 1'b1);
    check("R4 stuck low", fail_det, 1'b1);

    // R7: sticky across disarm, then cleared
    arm = 1'b0;
    repeat (200) @(negedge obs_clk);
    check("R7 sticky", fail_det, 1'b1);
    pulse_clr();
    check("R7 cleared", fail_det, 1'b0);

    // R8: disarm mid-window restarts the divider; stuck high
    ext_mode = 1;
    repeat (20) @(negedge obs_clk);
    arm_after_fall();
    wait_rises(base + 50, 2);
    arm = 1'b0;
    repeat (12) @(negedge obs_clk);
    check("R8 disarmed", fail_det, 1'b0);
    arm_after_fall();
    wait_rises(base + 63, 7);
    check("R8 full window after re-arm", fail_det, 1'b0);
    wait_rises(base + 64, 3);
    check("R4 stuck high", fail_det, 1'b1);

    // R6: lone fall in the low half only
    arm = 1'b0;
    pulse_clr();
    ext_mode = 0;
    repeat (20) @(negedge obs_clk);
    arm_after_fall();
    wait_rises(base + 10, 1);
    ext_pulse();
    wait_rises(base + 64, 3);
    check("R6 early fall ignored", fail_det, 1'b1);

    // R5: lone fall in the high half saves that window only
    arm = 1'b0;
    pulse_clr();
    repeat (20) @(negedge obs_clk);
    arm_after_fall();
    wait_rises(base + 40, 1);
    ext_pulse();
    wait_rises(base + 64, 3);
    check("R5 late fall counted", fail_det, 1'b0);
    wait_rises(base + 128, 3);
    check("R5 next window fails", fail_det, 1'b1);

    // R1: reset clears a latched failure
    @(negedge obs_clk); rst_n = 1'b0;
    @(negedge obs_clk);
    check("R1 reset clears", fail_det, 1'b0);
    arm = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge obs_clk);
    check("R1 idle after reset", fail_det, 1'b0);

    finish_run();
  end

endmodule